// File: doc/BRIEF.md
# Accumulator Postprocessing Output Unit

This block sits at the end of a wide SIMD compute pipeline. On a start pulse it captures one vector of signed 32-bit accumulator lanes. It applies an activation function to every lane, then reduces each lane to a storable format. The result leaves as a short burst of byte-per-lane vectors, one per cycle. Each beat carries a beat index and exactly one destination strobe. The strobe sends the vector back to the permute stage or to one of two vector memories.

Activation works on the accumulator read as a signed fixed-point number with FRAC_W fractional bits. The default is Q16.16, so 1.0 is 65536. The activation is applied first and the format conversion second. The lane count and the fraction width are parameters. The default configuration has four lanes.

Top module: `acc_output_unit`

## Requirements
- R1: While reset is high and in the cycle after it, `busy`, `done`, `fwd_valid`, `mem_a_we` and `mem_b_we` are all 0.
- R2: A `start` sampled while idle captures the inputs. From the next cycle, `busy` is 1 for N consecutive cycles, with `beat_idx` running 0, 1, … N-1. N is 1 for format code 0 (INT8), 2 for code 1 (INT16), 2 for code 2 (bfloat16) and 4 for code 3 (32-bit).
- R3: INT8 output: the lane is arithmetically shifted right by `rq_shift`, adding 2^(rq_shift-1) before the shift when `rq_shift` is nonzero (round half up). The result saturates to [-128, 127] and is emitted in beat 0.
- R4: INT16 output uses the same rounding shift, saturates to [-32768, 32767], and emits the low byte in beat 0 and the high byte in beat 1.
- R5: Bfloat16 output converts the signed integer lane to bfloat16 with round-to-nearest-even; zero maps to 0x0000. The mantissa-side low byte is emitted in beat 0 and the sign/exponent byte in beat 1. `rq_shift` has no effect.
- R6: 32-bit output emits byte k of the activated lane in beat k, for k = 0..3. `rq_shift` has no effect.
- R7: Activation code 1 (ReLU) replaces negative lanes with 0. Code 0 passes the lane unchanged.
- R8: Activation code 2 (sigmoid) gives (x >>> 2) + 0.5, clamped to [0, 1.0], in the same fixed point.
- R9: Activation code 3 (tanh) clamps x to [-1.0, 1.0].
- R10: Destination code 1 drives `mem_a_we` and code 2 drives `mem_b_we`. Codes 0 and 3 drive `fwd_valid`. The chosen strobe is high on every beat, and at most one strobe is high in any cycle.
- R11: A `start` while `busy` is ignored. The burst in progress keeps its data, format, destination and length, and no second burst follows.
- R12: `done` is high for exactly the one cycle after the last beat, and `busy` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst (taken only when idle) |
| acc_vec | input | LANES*32 | Accumulator lanes, lane 0 in the low bits |
| fmt_sel | input | 2 | 0 INT8, 1 INT16, 2 bfloat16, 3 full 32-bit |
| act_sel | input | 2 | 0 none, 1 ReLU, 2 sigmoid, 3 tanh |
| rq_shift | input | 5 | Requantization right shift for INT8/INT16 |
| dest_sel | input | 2 | 0/3 forward, 1 memory A, 2 memory B |
| vec_out | output | LANES*8 | Current output vector, one byte per lane |
| fwd_valid | output | 1 | Beat goes to the permute stage |
| mem_a_we | output | 1 | Beat is written to memory A |
| mem_b_we | output | 1 | Beat is written to memory B |
| beat_idx | output | 2 | Index of the current beat |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
The hardest cases to reach from the ports are rounding boundaries: exact ties for round-half-up and round-to-nearest-even, and lanes whose rounding carries into the bfloat16 exponent. A second hard case is a start that arrives while a burst is running and carries different data, format and destination. The bench reaches both with a sweep. It covers every format, activation and a set of shifts, over a pool of lane values placed on those boundaries. On every other burst it injects a conflicting start and changes the inputs during the first beat. The bfloat16 expectation comes from a double-precision conversion in the bench, not from the integer method the design uses.

// File: rtl/ou_pkg.sv
package ou_pkg;

    localparam int ACC_W = 32;

    typedef enum logic [1:0] {
        FMT_I8   = 2'd0,
        FMT_I16  = 2'd1,
        FMT_BF16 = 2'd2,
        FMT_I32  = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_RELU = 2'd1,
        ACT_SIGM = 2'd2,
        ACT_TANH = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        DST_FWD  = 2'd0,
        DST_MEMA = 2'd1,
        DST_MEMB = 2'd2,
        DST_FWD2 = 2'd3
    } dest_e;

    typedef struct packed {
        fmt_e       fmt;
        act_e       act;
        logic [4:0] shift;
        dest_e      dest;
    } cfg_t;

    // index of the final beat of a burst for a given format
    function automatic logic [1:0] last_beat_of(fmt_e f);
        case (f)
            FMT_I8:  return 2'd0;
            FMT_I16: return 2'd1;
            FMT_BF16: return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    // position of the most significant set bit (0 when v is zero)
    function automatic logic [4:0] msb_index(logic [ACC_W-1:0] v);
        logic [4:0] idx;
        idx = '0;
        for (int i = 0; i < ACC_W; i++) begin
            if (v[i]) idx = 5'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/ou_activation.sv
module ou_activation
    import ou_pkg::*;
#(
    parameter int FRAC_W = 16
) (
    input  logic signed [ACC_W-1:0] x,
    input  act_e                    mode,
    output logic signed [ACC_W-1:0] y
);
    localparam logic signed [ACC_W-1:0] ONE     = ACC_W'(64'd1 << FRAC_W);
    localparam logic signed [ACC_W-1:0] HALF    = ONE >>> 1;
    localparam logic signed [ACC_W-1:0] NEG_ONE = -ONE;

    logic signed [ACC_W-1:0] ramp;

    // sigmoid middle segment: slope 1/4 through 0.5
    assign ramp = (x >>> 2) + HALF;

    always_comb begin
        case (mode)
            ACT_RELU: y = x[ACC_W-1] ? '0 : x;                 // R7
            ACT_SIGM: begin                                   // R8
                if (ramp < 0)        y = '0;
                else if (ramp > ONE) y = ONE;
                else                 y = ramp;
            end
            ACT_TANH: begin                                   // R9
                if (x < NEG_ONE)     y = NEG_ONE;
                else if (x > ONE)    y = ONE;
                else                 y = x;
            end
            default:  y = x;
        endcase
    end
endmodule

// File: rtl/ou_convert.sv
module ou_convert
    import ou_pkg::*;
(
    input  logic signed [ACC_W-1:0] x,
    input  fmt_e                    fmt,
    input  logic [4:0]              shift,
    output logic [ACC_W-1:0]        word
);
    localparam logic signed [ACC_W:0] I8_HI  = 33'sd127;
    localparam logic signed [ACC_W:0] I8_LO  = -33'sd128;
    localparam logic signed [ACC_W:0] I16_HI = 33'sd32767;
    localparam logic signed [ACC_W:0] I16_LO = -33'sd32768;

    // rounding right shift for the integer formats (R3, R4)
    logic signed [ACC_W:0] ext, bias, sum, q;
    logic [7:0]  q8;
    logic [15:0] q16;

    always_comb begin
        ext  = {x[ACC_W-1], x};
        bias = '0;
        if (shift != 5'd0) bias[shift - 5'd1] = 1'b1;
        sum  = ext + bias;
        q    = sum >>> shift;
        if (q > I8_HI)       q8 = 8'h7F;
        else if (q < I8_LO)  q8 = 8'h80;
        else                 q8 = q[7:0];
        if (q > I16_HI)      q16 = 16'h7FFF;
        else if (q < I16_LO) q16 = 16'h8000;
        else                 q16 = q[15:0];
    end

    // integer to bfloat16, round to nearest even (R5)
    logic [ACC_W-1:0] mag, low_mask;
    logic [4:0]       msb, sh;
    logic [7:0]       top;
    logic [7:0]       expo;
    logic             guard, sticky, up;
    logic [14:0]      body;
    logic [15:0]      bf;

    always_comb begin
        mag      = x[ACC_W-1] ? (~x + 1'b1) : x;
        msb      = msb_index(mag);
        expo     = 8'd127 + {3'b000, msb};
        sh       = '0;
        top      = '0;
        guard    = 1'b0;
        sticky   = 1'b0;
        up       = 1'b0;
        low_mask = '0;
        body     = '0;
        if (mag == '0) begin
            bf = 16'h0000;
        end else if (msb <= 5'd7) begin
            top  = 8'(mag << (5'd7 - msb));
            body = {expo, top[6:0]};
            bf   = {x[ACC_W-1], body};
        end else begin
            sh       = msb - 5'd7;
            top      = 8'(mag >> sh);
            guard    = mag[sh - 5'd1];
            low_mask = (32'd1 << (sh - 5'd1)) - 32'd1;
            sticky   = |(mag & low_mask);
            up       = guard & (sticky | top[0]);
            body     = {expo, top[6:0]} + {14'd0, up};
            bf       = {x[ACC_W-1], body};
        end
    end

    always_comb begin
        case (fmt)
            FMT_I8:   word = {24'd0, q8};
            FMT_I16:  word = {16'd0, q16};
            FMT_BF16: word = {16'd0, bf};
            default:  word = x;                               // R6
        endcase
    end
endmodule

// File: rtl/ou_beat_ctrl.sv
module ou_beat_ctrl
    import ou_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  fmt_e       fmt_in,
    output logic       accept,
    output logic       busy,
    output logic       done,
    output logic [1:0] beat
);
    logic [1:0] last_q;

    // R11: a start while busy never reaches the capture path
    assign accept = start & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            beat   <= '0;
            last_q <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy   <= 1'b1;
                beat   <= '0;
                last_q <= last_beat_of(fmt_in);
            end else if (busy) begin
                if (beat == last_q) begin
                    busy <= 1'b0;
                    done <= 1'b1;                             // R12
                end else begin
                    beat <= beat + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/acc_output_unit.sv
module acc_output_unit
    import ou_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int FRAC_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [LANES*32-1:0]    acc_vec,
    input  logic [1:0]             fmt_sel,
    input  logic [1:0]             act_sel,
    input  logic [4:0]             rq_shift,
    input  logic [1:0]             dest_sel,
    output logic [LANES*8-1:0]     vec_out,
    output logic                   fwd_valid,
    output logic                   mem_a_we,
    output logic                   mem_b_we,
    output logic [1:0]             beat_idx,
    output logic                   busy,
    output logic                   done
);
    localparam int VEC_W = LANES * ACC_W;

    logic             accept;
    cfg_t             cfg_q;
    logic [VEC_W-1:0] acc_q;

    ou_beat_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .fmt_in (fmt_e'(fmt_sel)),
        .accept (accept),
        .busy   (busy),
        .done   (done),
        .beat   (beat_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            acc_q <= '0;
        end else if (accept) begin
            cfg_q.fmt   <= fmt_e'(fmt_sel);
            cfg_q.act   <= act_e'(act_sel);
            cfg_q.shift <= rq_shift;
            cfg_q.dest  <= dest_e'(dest_sel);
            acc_q       <= acc_vec;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [ACC_W-1:0] lane_in, lane_act;
        logic [ACC_W-1:0]        lane_word;

        assign lane_in = acc_q[l*ACC_W +: ACC_W];

        ou_activation #(.FRAC_W(FRAC_W)) u_act (
            .x    (lane_in),
            .mode (cfg_q.act),
            .y    (lane_act)
        );

        ou_convert u_cvt (
            .x     (lane_act),
            .fmt   (cfg_q.fmt),
            .shift (cfg_q.shift),
            .word  (lane_word)
        );

        assign vec_out[l*8 +: 8] = lane_word[{beat_idx, 3'b000} +: 8];
    end

    // R10: one strobe per beat, picked by the captured destination
    always_comb begin
        fwd_valid = 1'b0;
        mem_a_we  = 1'b0;
        mem_b_we  = 1'b0;
        if (busy) begin
            case (cfg_q.dest)
                DST_MEMA: mem_a_we  = 1'b1;
                DST_MEMB: mem_b_we  = 1'b1;
                default:  fwd_valid = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ou_checker.sv
module ou_checker (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       fwd_valid,
    input logic       mem_a_we,
    input logic       mem_b_we,
    input logic [1:0] beat_idx
);
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !fwd_valid && !mem_a_we && !mem_b_we));

    p_first_beat_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (beat_idx == 2'd0));

    p_beat_step_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (beat_idx == $past(beat_idx) + 2'd1));

    p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fwd_valid, mem_a_we, mem_b_we}));

    p_strobe_each_beat_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($countones({fwd_valid, mem_a_we, mem_b_we}) == 1));

    p_dest_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable({fwd_valid, mem_a_we, mem_b_we}));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));
endmodule

bind acc_output_unit ou_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .fwd_valid (fwd_valid),
    .mem_a_we  (mem_a_we),
    .mem_b_we  (mem_b_we),
    .beat_idx  (beat_idx)
);

// File: tb/tb_acc_output_unit.sv
`timescale 1ns/1ps
module tb_acc_output_unit;
    localparam int LANES = 4;
    localparam int NPOOL = 32;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic [LANES*32-1:0] acc_vec = '0;
    logic [1:0]          fmt_sel = '0, act_sel = '0, dest_sel = '0;
    logic [4:0]          rq_shift = '0;
    logic [LANES*8-1:0]  vec_out;
    logic                fwd_valid, mem_a_we, mem_b_we, busy, done;
    logic [1:0]          beat_idx;

    always #4 clk = ~clk;

    acc_output_unit #(.LANES(LANES)) dut (
        .clk(clk), .rst(rst), .start(start), .acc_vec(acc_vec),
        .fmt_sel(fmt_sel), .act_sel(act_sel), .rq_shift(rq_shift),
        .dest_sel(dest_sel), .vec_out(vec_out), .fwd_valid(fwd_valid),
        .mem_a_we(mem_a_we), .mem_b_we(mem_b_we), .beat_idx(beat_idx),
        .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_fail = 0;

    int pool [0:NPOOL-1] = '{
        0, 1, -1, 2, -2, 127, 128, -128,
        -129, 32767, 32768, -32769, 65536, -65536, 98304, -98304,
        int'(32'h7FFFFFFF), int'(32'h80000000), int'(32'h01000080), int'(32'h01018000),
        int'(32'h00FF8000), 3, 5, -3,
        -5, int'(32'h12345678), -305419896, 385,
        131071, 262143, -262144, 24
    };

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int act_model(int x, int a);
        int t;
        case (a)
            1: return (x < 0) ? 0 : x;
            2: begin
                t = (x >>> 2) + 32768;
                if (t < 0) return 0;
                if (t > 65536) return 65536;
                return t;
            end
            3: begin
                if (x < -65536) return -65536;
                if (x > 65536) return 65536;
                return x;
            end
            default: return x;
        endcase
    endfunction

    function automatic logic [15:0] bf16_model(int x);
        logic [63:0] b;
        logic [51:0] m;
        logic [14:0] body;
        logic        up;
        if (x == 0) return 16'h0000;
        b = $realtobits(real'(x));
        m = b[51:0];
        up = m[44] & ((|m[43:0]) | m[45]);
        body = {8'(b[62:52] - 11'd896), m[51:45]} + {14'd0, up};
        return {b[63], body};
    endfunction

    function automatic logic [31:0] conv_model(int x, int f, int sh);
        longint s, q;
        s = longint'(x) + ((sh != 0) ? (64'sd1 <<< (sh - 1)) : 64'sd0);
        q = s >>> sh;
        case (f)
            0: begin
                if (q > 127) q = 127;
                if (q < -128) q = -128;
                return {24'd0, 8'(q)};
            end
            1: begin
                if (q > 32767) q = 32767;
                if (q < -32768) q = -32768;
                return {16'd0, 16'(q)};
            end
            2: return {16'd0, bf16_model(x)};
            default: return 32'(x);
        endcase
    endfunction

    function automatic string tag_of(int f, int a);
        string s;
        case (f)
            0: s = "R3 INT8";
            1: s = "R4 INT16";
            2: s = "R5 BF16";
            default: s = "R6 INT32";
        endcase
        case (a)
            1: s = {s, " R7 relu"};
            2: s = {s, " R8 sigmoid"};
            3: s = {s, " R9 tanh"};
            default: s = {s, " R7 pass"};
        endcase
        return s;
    endfunction

    task automatic run(int set, int f, int a, int sh, int dst, bit inject);
        int                  lv [LANES];
        logic [LANES*32-1:0] v;
        logic [LANES*8-1:0]  ev;
        logic [31:0]         w;
        logic [2:0]          es, as;
        int                  nb;
        for (int l = 0; l < LANES; l++) begin
            lv[l] = pool[(set * LANES + l * 3) % NPOOL];
            v[l*32 +: 32] = lv[l];
        end
        nb = (f == 0) ? 1 : (f == 3) ? 4 : 2;
        es = (dst == 1) ? 3'b010 : (dst == 2) ? 3'b001 : 3'b100;
        @(negedge clk);
        acc_vec = v; fmt_sel = 2'(f); act_sel = 2'(a);
        rq_shift = 5'(sh); dest_sel = 2'(dst); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int b = 0; b < nb; b++) begin
            for (int l = 0; l < LANES; l++) begin
                w = conv_model(act_model(lv[l], a), f, sh);
                ev[l*8 +: 8] = w[b*8 +: 8];
            end
            check(vec_out == ev, inject ? {tag_of(f, a), " R11"} : tag_of(f, a),
                  64'(vec_out), 64'(ev));
            check(busy && beat_idx == 2'(b), "R2 beat", {62'd0, beat_idx}, 64'(b));
            as = {fwd_valid, mem_a_we, mem_b_we};
            check(as == es, "R10 strobe", 64'(as), 64'(es));
            if (inject && b == 0) begin
                start = 1'b1; acc_vec = ~v;
                fmt_sel = 2'(f + 1); dest_sel = 2'(dst + 1);
            end
            @(negedge clk);
            start = 1'b0;
        end
        check(done && !busy, "R12 done after last beat", {62'd0, done, busy}, 64'b10);
        @(negedge clk);
        as = {fwd_valid, mem_a_we, mem_b_we};
        check(!done && !busy && as == 3'b000, inject ? "R11 no second burst" : "R12 single pulse",
              {60'd0, done, busy, 2'b00} | 64'(as), 64'd0);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int shifts [6] = '{0, 1, 2, 8, 16, 31};
        int k;
        repeat (3) @(negedge clk);
        check(!busy && !done && !fwd_valid && !mem_a_we && !mem_b_we, "R1 reset idle",
              {59'd0, busy, done, fwd_valid, mem_a_we, mem_b_we}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !fwd_valid && !mem_a_we && !mem_b_we, "R1 after reset",
              {59'd0, busy, done, fwd_valid, mem_a_we, mem_b_we}, 64'd0);
        k = 0;
        for (int f = 0; f < 4; f++)
            for (int a = 0; a < 4; a++)
                for (int si = 0; si < 6; si++)
                    for (int set = 0; set < 8; set++) begin
                        run(set + si, f, a, shifts[si], k % 4, (set % 2) == 1);
                        k++;
                    end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule